// File: doc/BRIEF.md
# DMA Strobe Timing Generator

This block paces the read or write strobe of a disk-drive DMA transfer. The caller gives a transfer mode, the minimum cycle time the drive reports, a word count and a direction, then pulses start. From these the block derives the cycle time it must honour. It picks one of four fixed timing profiles, each a pair of active and recovery lengths counted in 62.5 ns ticks. It then emits one strobe per word, each strobe followed by a recovery gap, until the count runs out or the caller aborts.

The tick is derived from the core clock by a parameterized divider (`TICK_CLKS` clocks per tick). At the end of a transfer, done pulses for one clock. The residue output then holds the number of words that were not transferred, and the error flag is set whenever that residue is nonzero. Only one transfer runs at a time. A start that arrives while the block is busy is refused and reported.

Top module: `ds_strobe_gen`

## Requirements
- R1: After reset, busy_o, done_o, rd_stb_o, wr_stb_o, err_o and reject_o are 0 and residue_o is 0.
- R2: The required cycle time depends on mode_i, where bit 2 set means multiword and bits 1:0 give the mode level. Multiword levels 1 and 2 require the larger of 250 ns and drive_cyc_i. Every other mode requires 480 ns.
- R3: The profile is the fastest one whose cycle (ticks x 62.5 ns) is at least the required cycle. If no profile qualifies, the slowest one is used. The profiles in ticks (active/recovery) are slow 4/5, medium 3/4, fast 2/2 and fastest 1/2, reported on type_o as 0, 1, 2 and 3. type_o is latched when start is accepted and holds until the next accepted start.
- R4: Each word's strobe is high for active x TICK_CLKS clocks and then low for recovery x TICK_CLKS clocks. The first strobe begins in the clock after start is accepted.
- R5: With dir_i=1 only wr_stb_o pulses; with dir_i=0 only rd_stb_o pulses; the two are never high together.
- R6: A transfer of N words gives exactly N strobes. busy_o is high from the clock after start for N x (active+recovery) x TICK_CLKS clocks, then for the one done clock, and is low after that.
- R7: done_o is high for exactly one clock at the end of a transfer. After a full transfer, residue_o is 0 and err_o is 0.
- R8: A start with count_i=0 produces no strobe. done_o rises in the first clock after start, with residue_o 0 and err_o 0.
- R9: abort_i sampled high during the strobe phases ends the transfer. done_o is high in the next clock and both strobes are low. residue_o gives the words whose recovery had not completed, and err_o is 1.
- R10: start_i sampled while busy_o is high pulses reject_o in the next clock and leaves the running transfer unchanged.
- R11: abort_i while idle has no effect: busy_o and done_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a transfer |
| dir_i | input | 1 | 1 = write, 0 = read |
| mode_i | input | 3 | Bit 2 multiword, bits 1:0 mode level |
| drive_cyc_i | input | CYC_W | Drive's reported minimum cycle, ns |
| count_i | input | CNT_W | Words to transfer |
| abort_i | input | 1 | Stop the running transfer |
| rd_stb_o | output | 1 | Read strobe |
| wr_stb_o | output | 1 | Write strobe |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-clock end-of-transfer pulse |
| err_o | output | 1 | Last transfer ended with residue |
| residue_o | output | CNT_W | Words not transferred |
| type_o | output | 2 | Selected timing profile |
| reject_o | output | 1 | Start refused while busy |

## Verification
A wrong phase counter or a wrong profile changes the length of the very first strobe, so the bench compares each clock of the strobe waveform against a model of it. That exposes the fault within one word time. A wrong word counter moves the done clock and the busy length, and it also appears in residue_o when an abort is injected at a random point. Refused starts are injected in mid-transfer to show that the running waveform continues undisturbed.

// File: rtl/ds_pkg.sv
package ds_pkg;
    typedef enum logic [1:0] {TY_SLOW = 2'd0, TY_MED = 2'd1, TY_FAST = 2'd2, TY_FASTEST = 2'd3} ty_e;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ACT = 2'd1, ST_REC = 2'd2, ST_FIN = 2'd3} st_e;

    localparam int PH_W = 3;
    localparam int NS_PER_2TICK = 125;

    function automatic logic [PH_W-1:0] act_ticks(ty_e t);
        case (t)
            TY_SLOW: act_ticks = 3'd4;
            TY_MED:  act_ticks = 3'd3;
            TY_FAST: act_ticks = 3'd2;
            default: act_ticks = 3'd1;
        endcase
    endfunction

    function automatic logic [PH_W-1:0] rec_ticks(ty_e t);
        case (t)
            TY_SLOW: rec_ticks = 3'd5;
            TY_MED:  rec_ticks = 3'd4;
            default: rec_ticks = 3'd2;
        endcase
    endfunction
endpackage

// File: rtl/ds_type_sel.sv
module ds_type_sel
    import ds_pkg::*;
#(
    parameter int CYC_W = 10
) (
    input  logic [2:0]       mode_i,
    input  logic [CYC_W-1:0] drive_cyc_i,
    output ty_e              type_o
);
    localparam int MW_FLOOR_NS = 250;
    localparam int BASE_NS     = 480;

    int req_ns;

    always_comb begin
        if (mode_i[2] && (mode_i[1:0] == 2'd1 || mode_i[1:0] == 2'd2))
            req_ns = (int'(drive_cyc_i) > MW_FLOOR_NS) ? int'(drive_cyc_i) : MW_FLOOR_NS;
        else
            req_ns = BASE_NS;
    end

    always_comb begin
        type_o = TY_SLOW;
        for (int i = 0; i < 4; i++) begin
            if (2 * req_ns <= (int'(act_ticks(ty_e'(2'(i)))) + int'(rec_ticks(ty_e'(2'(i))))) * NS_PER_2TICK)
                type_o = ty_e'(2'(i));
        end
    end
endmodule

// File: rtl/ds_tick_gen.sv
module ds_tick_gen #(
    parameter int TICK_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    generate
        if (TICK_CLKS <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(TICK_CLKS);
            logic [DW-1:0] div_d, div_q;
            always_comb begin
                if (clr_i || div_q == DW'(TICK_CLKS - 1)) div_d = '0;
                else                                      div_d = div_q + 1'b1;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) div_q <= '0;
                else        div_q <= div_d;
            end
            assign tick_o = !clr_i && (div_q == DW'(TICK_CLKS - 1));
        end
    endgenerate
endmodule

// File: rtl/ds_strobe_gen.sv
module ds_strobe_gen
    import ds_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int CYC_W     = 10,
    parameter int TICK_CLKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             dir_i,
    input  logic [2:0]       mode_i,
    input  logic [CYC_W-1:0] drive_cyc_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             abort_i,
    output logic             rd_stb_o,
    output logic             wr_stb_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [CNT_W-1:0] residue_o,
    output logic [1:0]       type_o,
    output logic             reject_o
);
    typedef struct packed {
        st_e             st;
        ty_e             ty;
        logic            dir;
        logic [CNT_W-1:0] words;
        logic [PH_W-1:0] ph;
        logic            err;
        logic            reject;
    } regs_t;

    regs_t r_d, r_q;
    ty_e   sel_ty;
    logic  tick;

    ds_type_sel #(.CYC_W(CYC_W)) u_sel (
        .mode_i      (mode_i),
        .drive_cyc_i (drive_cyc_i),
        .type_o      (sel_ty)
    );

    ds_tick_gen #(.TICK_CLKS(TICK_CLKS)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (r_q.st == ST_IDLE),
        .tick_o (tick)
    );

    always_comb begin
        r_d        = r_q;
        r_d.reject = start_i && (r_q.st != ST_IDLE);
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.ty    = sel_ty;
                    r_d.dir   = dir_i;
                    r_d.words = count_i;
                    r_d.err   = 1'b0;
                    r_d.ph    = act_ticks(sel_ty);
                    r_d.st    = (count_i == '0) ? ST_FIN : ST_ACT;
                end
            end
            ST_ACT: begin
                if (abort_i) begin
                    r_d.st  = ST_FIN;
                    r_d.err = 1'b1;
                end else if (tick) begin
                    if (r_q.ph == PH_W'(1)) begin
                        r_d.st = ST_REC;
                        r_d.ph = rec_ticks(r_q.ty);
                    end else begin
                        r_d.ph = r_q.ph - 1'b1;
                    end
                end
            end
            ST_REC: begin
                if (abort_i) begin
                    r_d.st  = ST_FIN;
                    r_d.err = 1'b1;
                end else if (tick) begin
                    if (r_q.ph == PH_W'(1)) begin
                        r_d.words = r_q.words - 1'b1;
                        r_d.ph    = act_ticks(r_q.ty);
                        r_d.st    = (r_q.words == CNT_W'(1)) ? ST_FIN : ST_ACT;
                    end else begin
                        r_d.ph = r_q.ph - 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, ty: TY_SLOW, dir: 1'b0, words: '0, ph: '0, err: 1'b0, reject: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o    = (r_q.st != ST_IDLE);
    assign done_o    = (r_q.st == ST_FIN);
    assign rd_stb_o  = (r_q.st == ST_ACT) && !r_q.dir;
    assign wr_stb_o  = (r_q.st == ST_ACT) && r_q.dir;
    assign err_o     = r_q.err;
    assign residue_o = r_q.words;
    assign type_o    = r_q.ty;
    assign reject_o  = r_q.reject;

    p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb_o && wr_stb_o));
    p_strobe_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_o || wr_stb_o) |-> busy_o);
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_abort_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && busy_o && !done_o) |=> (done_o && err_o && !rd_stb_o && !wr_stb_o));
    p_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> reject_o);
    p_type_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(type_o));
    p_idle_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !busy_o);
endmodule

// File: tb/tb_ds_strobe_gen.sv
module tb_ds_strobe_gen;
    localparam int CNT_W = 16;
    localparam int CYC_W = 10;
    localparam int TCK   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, dir_i = 1'b0, abort_i = 1'b0;
    logic [2:0] mode_i = '0;
    logic [CYC_W-1:0] drive_cyc_i = '0;
    logic [CNT_W-1:0] count_i = '0;
    logic rd_stb_o, wr_stb_o, busy_o, done_o, err_o, reject_o;
    logic [CNT_W-1:0] residue_o;
    logic [1:0] type_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ds_strobe_gen #(.CNT_W(CNT_W), .CYC_W(CYC_W), .TICK_CLKS(TCK)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i), .mode_i(mode_i),
        .drive_cyc_i(drive_cyc_i), .count_i(count_i), .abort_i(abort_i),
        .rd_stb_o(rd_stb_o), .wr_stb_o(wr_stb_o), .busy_o(busy_o), .done_o(done_o),
        .err_o(err_o), .residue_o(residue_o), .type_o(type_o), .reject_o(reject_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int m_req(input int mode, input int drv);
        if (mode >= 4 && (mode % 4 == 1 || mode % 4 == 2)) return (drv > 250) ? drv : 250;
        return 480;
    endfunction

    function automatic int m_act(input int ty);
        case (ty) 0: return 4; 1: return 3; 2: return 2; default: return 1; endcase
    endfunction

    function automatic int m_rec(input int ty);
        case (ty) 0: return 5; 1: return 4; default: return 2; endcase
    endfunction

    function automatic int m_type(input int req);
        int t = 0;
        for (int i = 0; i < 4; i++)
            if (2 * req <= (m_act(i) + m_rec(i)) * 125) t = i;
        return t;
    endfunction

    // inj_rej / inj_ab: cycle index of injected start / abort, -1 for none
    task automatic xfer(input int mode, input int drv, input int n, input bit dir,
                        input int inj_rej, input int inj_ab);
        int ty, a, p, end_t, ab, bad_stb, bad_other, bad_done, bad_busy, exp_res;
        bit s, o, exp_s;
        ty = m_type(m_req(mode, drv));
        a = m_act(ty) * TCK;
        p = (m_act(ty) + m_rec(ty)) * TCK;
        ab = (inj_ab >= 0 && inj_ab < n * p) ? inj_ab : -1;
        end_t = (ab >= 0) ? ab + 1 : n * p;
        exp_res = (ab >= 0) ? n - ab / p : 0;
        bad_stb = 0; bad_other = 0; bad_done = 0; bad_busy = 0;
        @(negedge clk);
        mode_i = 3'(mode); drive_cyc_i = CYC_W'(drv); count_i = CNT_W'(n); dir_i = dir;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(type_o == 2'(ty), "R3 type", int'(type_o), ty);
        for (int t = 0; t <= end_t; t++) begin
            if (t > 0) @(negedge clk);
            s = dir ? wr_stb_o : rd_stb_o;
            o = dir ? rd_stb_o : wr_stb_o;
            exp_s = (t < end_t) && (t < n * p) && ((t % p) < a);
            if (s != exp_s) bad_stb++;
            if (o) bad_other++;
            if (done_o != (t == end_t)) bad_done++;
            if (!busy_o) bad_busy++;
            if (inj_rej >= 0 && t == inj_rej + 1) begin
                start_i = 1'b0;
                chk(reject_o == 1'b1, "R10 reject pulse", int'(reject_o), 1);
            end
            if (t == inj_rej && t < end_t) begin
                start_i = 1'b1; count_i = CNT_W'(n + 3); dir_i = !dir;
            end
            abort_i = (t == ab);
        end
        start_i = 1'b0;
        abort_i = 1'b0;
        chk(bad_stb == 0, (ab >= 0) ? "R9 strobe waveform" : "R4 strobe waveform", bad_stb, 0);
        chk(bad_other == 0, "R5 opposite strobe idle", bad_other, 0);
        chk(bad_done == 0, (n == 0) ? "R8 done timing" : "R7 done timing", bad_done, 0);
        chk(bad_busy == 0, "R6 busy span", bad_busy, 0);
        chk(residue_o == CNT_W'(exp_res), (ab >= 0) ? "R9 residue" : "R7 residue", int'(residue_o), exp_res);
        chk(err_o == (exp_res != 0), (ab >= 0) ? "R9 err" : "R7 err", int'(err_o), int'(exp_res != 0));
        @(negedge clk);
        chk(!busy_o && !done_o, "R6 idle after done", int'(busy_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !rd_stb_o && !wr_stb_o && !err_o && !reject_o && residue_o == 0,
            "R1 reset state", int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corners
        xfer(0, 0, 2, 1'b0, -1, -1);      // R2 single-word -> slow
        xfer(5, 100, 3, 1'b1, -1, -1);    // R2 MW1 floor 250 -> fast
        xfer(6, 437, 2, 1'b0, -1, -1);    // R3 exact 437 -> medium
        xfer(6, 438, 1, 1'b1, -1, -1);    // R3 438 -> slow
        xfer(5, 900, 1, 1'b0, -1, -1);    // R3 none fits -> slow
        xfer(4, 900, 1, 1'b0, -1, -1);    // R2 MW0 ignores drive
        xfer(2, 0, 0, 1'b1, -1, -1);      // R8 zero count
        xfer(5, 250, 4, 1'b1, 5, -1);     // R10 reject mid-transfer
        xfer(6, 300, 3, 1'b0, -1, 13);    // R9 abort at recovery end
        xfer(0, 0, 3, 1'b1, -1, 0);       // R9 abort first cycle
        // R11 abort while idle
        abort_i = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o, "R11 idle abort", int'(busy_o | done_o), 0);
        abort_i = 1'b0;
        // random mix
        for (int k = 0; k < 40; k++) begin
            int md, dv, n, rj, ab;
            md = int'($urandom_range(7, 0));
            dv = int'($urandom_range(700, 100));
            n  = int'($urandom_range(5, 0));
            rj = ($urandom_range(3, 0) == 0) ? int'($urandom_range(20, 0)) : -1;
            ab = ($urandom_range(3, 0) == 0) ? int'($urandom_range(40, 0)) : -1;
            xfer(md, dv, n, 1'($urandom_range(1, 0)), rj, ab);
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule